// File: doc/BRIEF.md
# Down-Spread Clock Frequency Modulator

This block feeds a fractional clock divider with a divide ratio that changes over time, so that the divided clock spends a controlled share of each modulation period below its nominal frequency. Because a larger divide ratio means a lower output frequency, the ratio only ever moves upward from the nominal value. The spread energy is spread out in frequency, which lowers peak emissions. The profile is a symmetric linear triangle. Its peak offset is a whole number of tenths of a percent of the nominal ratio.

The modulation rate comes from the reference clock. A prescaler with a programmable terminal count clocks a position counter that walks up and down the triangle. Spreading runs only when all of these hold: the global enable is high, the output is marked spread-capable, the output is fed from the first PLL, and the depth code is legal. When any of these drops, the ratio finishes its current triangle and settles at exactly the nominal value. The depth code is captured at each triangle minimum, so a change takes effect from the next period and never causes a step.

The nominal ratio is an unsigned fixed-point value with any binary point position. The offset keeps the same scaling. Callers must leave 2.5% headroom in `RATIO_W`.

Top module: `dsm_spread_mod`

## Requirements
- R1: While reset is held and just after it is released, `ratio_o` equals `nom_ratio_i`.
- R2: `ratio_o` is never below `nom_ratio_i` (down-spread only).
- R3: With a depth code c in 1..25 (c × 0.1 %), the largest ratio in a period is nom + floor(nom × c / 1000) and the smallest is exactly nom.
- R4: The ratio ramps linearly. Between consecutive cycles it changes by at most floor(nom × c / (1000 × STEPS)) + 1, and the triangle position changes by at most one.
- R5: One modulation period is 2 × STEPS × (rate_tc_i + 1) reference cycles. With STEPS = 64, tc = 5 at 25 MHz gives about 32.55 kHz and tc = 6 at 27 MHz gives about 30.13 kHz, both inside 30–33 kHz.
- R6: With `spread_en_i` low, `ratio_o` stays at nominal.
- R7: With `pll_sel_i` = 1 (second PLL), `ratio_o` stays at nominal whatever the other inputs are. The value 0 selects the first PLL.
- R8: With `spread_cap_i` low, `ratio_o` stays at nominal.
- R9: A depth code of 0 or above 25 (5-bit field) means no spread: `ratio_o` stays at nominal.
- R10: If spreading is disabled in the middle of a triangle, the ratio keeps following the ramp with no step. It reaches exactly nominal within one period and then stays there.
- R11: The depth code is sampled at the triangle minimum. A change during a period leaves that period's peak unchanged and applies from the next period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| nom_ratio_i | input | RATIO_W | Nominal divide ratio, unsigned fixed point |
| depth_code_i | input | CODE_W | Spread depth in 0.1 % units, legal 1..MAX_CODE |
| spread_cap_i | input | 1 | This output is configured for spreading |
| pll_sel_i | input | 1 | Source PLL: 0 = first (may spread), 1 = second (never spreads) |
| spread_en_i | input | 1 | Global spread enable, active high |
| rate_tc_i | input | TC_W | Prescaler terminal count; one triangle step per tc+1 cycles |
| ratio_o | output | RATIO_W | Instantaneous divide ratio |

## Verification
The bench uses the default STEPS = 64, a 32-bit ratio and a 5-bit code. It drives terminal counts of 0 to 7, which keeps one modulation period between 128 and 1024 cycles. At that length many full triangles fit in the run, so the peak, the minimum, the period and the per-cycle step can each be measured several times under random nominal ratios and depths. Nominal ratios of at least 2^22 make adjacent triangle steps distinct, so the peak plateau and its start cycle can be identified exactly. The terminal counts 5 and 6 place the 25 MHz and 27 MHz reference cases inside the same budget.

// File: rtl/dsm_pkg.sv
package dsm_pkg;
  typedef enum logic {
    SRC_PLL_A = 1'b0,
    SRC_PLL_B = 1'b1
  } pll_src_e;

  typedef enum logic {
    RAMP_UP   = 1'b0,
    RAMP_DOWN = 1'b1
  } ramp_dir_e;
endpackage

// File: rtl/dsm_rate_gen.sv
module dsm_rate_gen #(
  parameter int TC_W = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [TC_W-1:0] tc_i,
  output logic            tick_o
);
  logic [TC_W-1:0] cnt_q;
  logic            wrap;

  // >= so a terminal count lowered on the fly still wraps at once
  assign wrap   = (cnt_q >= tc_i);
  assign tick_o = wrap;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   cnt_q <= '0;
    else if (wrap) cnt_q <= '0;
    else           cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/dsm_triangle.sv
module dsm_triangle
  import dsm_pkg::*;
#(
  parameter int STEPS  = 64,
  parameter int CODE_W = 5,
  localparam int POS_W = $clog2(STEPS + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              allow_i,
  input  logic [CODE_W-1:0] code_i,
  output logic [POS_W-1:0]  pos_o,
  output logic [CODE_W-1:0] code_o
);
  logic [POS_W-1:0]  pos_q;
  logic [CODE_W-1:0] code_q;
  ramp_dir_e         dir_q;

  // pos 0 is the triangle minimum: the only point where a new period may start
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pos_q  <= '0;
      code_q <= '0;
      dir_q  <= RAMP_UP;
    end else if (tick_i) begin
      if (pos_q == '0) begin
        if (allow_i) begin
          pos_q  <= POS_W'(1);
          code_q <= code_i;
          dir_q  <= RAMP_UP;
        end
      end else if (dir_q == RAMP_UP) begin
        pos_q <= pos_q + 1'b1;
        if (pos_q == POS_W'(STEPS - 1)) dir_q <= RAMP_DOWN;
      end else begin
        pos_q <= pos_q - 1'b1;
      end
    end
  end

  assign pos_o  = pos_q;
  assign code_o = code_q;
endmodule

// File: rtl/dsm_scaler.sv
module dsm_scaler #(
  parameter int RATIO_W   = 32,
  parameter int CODE_W    = 5,
  parameter int STEPS     = 64,
  parameter int PER_MILLE = 1000,
  localparam int POS_W    = $clog2(STEPS + 1),
  localparam int PROD_W   = RATIO_W + CODE_W + POS_W,
  localparam int DIVISOR  = PER_MILLE * STEPS
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [RATIO_W-1:0] nom_i,
  input  logic [CODE_W-1:0]  code_i,
  input  logic [POS_W-1:0]   pos_i,
  output logic [RATIO_W-1:0] off_o
);
  logic [PROD_W-1:0] prod;
  logic [PROD_W-1:0] quot;

  // nom * code/1000 * pos/STEPS, one truncation at the end
  assign prod = PROD_W'(nom_i) * PROD_W'(code_i) * PROD_W'(pos_i);
  assign quot = prod / PROD_W'(DIVISOR);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) off_o <= '0;
    else         off_o <= RATIO_W'(quot);
  end
endmodule

// File: rtl/dsm_spread_mod.sv
module dsm_spread_mod
  import dsm_pkg::*;
#(
  parameter int RATIO_W   = 32,
  parameter int CODE_W    = 5,
  parameter int MAX_CODE  = 25,
  parameter int TC_W      = 8,
  parameter int STEPS     = 64,
  parameter int PER_MILLE = 1000,
  localparam int POS_W    = $clog2(STEPS + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [RATIO_W-1:0] nom_ratio_i,
  input  logic [CODE_W-1:0]  depth_code_i,
  input  logic               spread_cap_i,
  input  logic               pll_sel_i,
  input  logic               spread_en_i,
  input  logic [TC_W-1:0]    rate_tc_i,
  output logic [RATIO_W-1:0] ratio_o
);
  logic              step_tick;
  logic              code_ok;
  logic              allow;
  logic [POS_W-1:0]  tri_pos;
  logic [CODE_W-1:0] tri_code;
  logic [RATIO_W-1:0] offset;

  assign code_ok = (depth_code_i != '0) && (depth_code_i <= CODE_W'(MAX_CODE));
  assign allow   = spread_en_i && spread_cap_i &&
                   (pll_src_e'(pll_sel_i) == SRC_PLL_A) && code_ok;

  dsm_rate_gen #(.TC_W(TC_W)) u_rate (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tc_i   (rate_tc_i),
    .tick_o (step_tick)
  );

  dsm_triangle #(.STEPS(STEPS), .CODE_W(CODE_W)) u_tri (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tick_i  (step_tick),
    .allow_i (allow),
    .code_i  (depth_code_i),
    .pos_o   (tri_pos),
    .code_o  (tri_code)
  );

  dsm_scaler #(
    .RATIO_W(RATIO_W), .CODE_W(CODE_W), .STEPS(STEPS), .PER_MILLE(PER_MILLE)
  ) u_scale (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .nom_i  (nom_ratio_i),
    .code_i (tri_code),
    .pos_i  (tri_pos),
    .off_o  (offset)
  );

  assign ratio_o = nom_ratio_i + offset;
endmodule

// File: rtl/dsm_spread_mod_chk.sv
module dsm_spread_mod_chk #(
  parameter int RATIO_W   = 32,
  parameter int CODE_W    = 5,
  parameter int MAX_CODE  = 25,
  parameter int STEPS     = 64,
  parameter int PER_MILLE = 1000,
  localparam int POS_W    = $clog2(STEPS + 1),
  localparam int WIDE_W   = RATIO_W + 16
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [RATIO_W-1:0] nom_ratio_i,
  input logic [CODE_W-1:0]  depth_code_i,
  input logic               spread_cap_i,
  input logic               pll_sel_i,
  input logic               spread_en_i,
  input logic               step_tick,
  input logic [POS_W-1:0]   tri_pos,
  input logic [RATIO_W-1:0] ratio_o
);
  logic may_start;
  assign may_start = spread_en_i && spread_cap_i && !pll_sel_i &&
                     (depth_code_i != '0) && (depth_code_i <= CODE_W'(MAX_CODE));

  // R2
  ratio_not_below_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ratio_o >= nom_ratio_i);

  // R3
  peak_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $stable(nom_ratio_i) |->
      (WIDE_W'(ratio_o) - WIDE_W'(nom_ratio_i)) * WIDE_W'(PER_MILLE)
        <= WIDE_W'(nom_ratio_i) * WIDE_W'(MAX_CODE));

  // R4
  pos_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (tri_pos == $past(tri_pos)) || (tri_pos == $past(tri_pos) + 1'b1) ||
             (tri_pos + 1'b1 == $past(tri_pos)));

  // R4
  pos_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tri_pos <= POS_W'(STEPS));

  // R5
  pos_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !step_tick |=> $stable(tri_pos));

  // R10
  min_is_nominal_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tri_pos == '0) |=> (ratio_o == nom_ratio_i));

  // R6
  start_gated_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tri_pos == '0) && !may_start |=> (tri_pos == '0));
endmodule

bind dsm_spread_mod dsm_spread_mod_chk #(
  .RATIO_W(RATIO_W), .CODE_W(CODE_W), .MAX_CODE(MAX_CODE),
  .STEPS(STEPS), .PER_MILLE(PER_MILLE)
) chk_i (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .nom_ratio_i  (nom_ratio_i),
  .depth_code_i (depth_code_i),
  .spread_cap_i (spread_cap_i),
  .pll_sel_i    (pll_sel_i),
  .spread_en_i  (spread_en_i),
  .step_tick    (step_tick),
  .tri_pos      (tri_pos),
  .ratio_o      (ratio_o)
);

// File: tb/dsm_spread_mod_tb_top.sv
module dsm_spread_mod_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int RATIO_W = 32;
  localparam int CODE_W  = 5;
  localparam int TC_W    = 8;
  localparam int STEPS   = 64;

  logic               clk = 1'b0;
  logic               rst_ni = 1'b0;
  logic [RATIO_W-1:0] nom_ratio_i = '0;
  logic [CODE_W-1:0]  depth_code_i = '0;
  logic               spread_cap_i = 1'b0;
  logic               pll_sel_i = 1'b0;
  logic               spread_en_i = 1'b0;
  logic [TC_W-1:0]    rate_tc_i = '0;
  logic [RATIO_W-1:0] ratio_o;

  always #(CLK_PERIOD / 2) clk = ~clk;

  dsm_spread_mod #(
    .RATIO_W(RATIO_W), .CODE_W(CODE_W), .TC_W(TC_W), .STEPS(STEPS)
  ) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .nom_ratio_i(nom_ratio_i),
    .depth_code_i(depth_code_i), .spread_cap_i(spread_cap_i),
    .pll_sel_i(pll_sel_i), .spread_en_i(spread_en_i),
    .rate_tc_i(rate_tc_i), .ratio_o(ratio_o)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  longint o_min, o_max, o_step, o_first, o_t1, o_t2;
  int     o_below, o_starts;

  function automatic longint f_peak(longint nom, longint code);
    return nom + (nom * code) / 1000;
  endfunction
  function automatic longint f_step(longint nom, longint code);
    return (nom * code) / (1000 * STEPS) + 1;
  endfunction
  function automatic longint f_period(longint tc);
    return 2 * STEPS * (tc + 1);
  endfunction

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic observe(input longint cycles, input longint peak);
    longint prev = 0;
    bit prev_pk = 0;
    o_min = 64'h7fff_ffff_ffff_ffff; o_max = 0; o_step = 0;
    o_below = 0; o_starts = 0; o_t1 = 0; o_t2 = 0;
    for (longint i = 0; i < cycles; i++) begin
      longint cur;
      bit pk;
      @(negedge clk);
      cur = longint'(ratio_o);
      if (i == 0) o_first = cur;
      if (cur < longint'(nom_ratio_i)) o_below++;
      if (cur < o_min) o_min = cur;
      if (cur > o_max) o_max = cur;
      if (i > 0) begin
        longint d = (cur > prev) ? cur - prev : prev - cur;
        if (d > o_step) o_step = d;
      end
      pk = (cur == peak);
      if (i > 0 && pk && !prev_pk) begin
        if (o_starts == 0) o_t1 = i;
        else if (o_starts == 1) o_t2 = i;
        o_starts++;
      end
      prev_pk = pk;
      prev = cur;
    end
  endtask

  task automatic drain();
    spread_en_i = 1'b0;
    repeat (int'(f_period(longint'(rate_tc_i))) + 2 * (int'(rate_tc_i) + 1) + 4) @(negedge clk);
  endtask

  task automatic run_cfg(input longint nom, input longint code, input longint tc);
    longint p = f_period(tc);
    longint pk = f_peak(nom, code);
    drain();
    nom_ratio_i = RATIO_W'(nom); depth_code_i = CODE_W'(code); rate_tc_i = TC_W'(tc);
    spread_cap_i = 1'b1; pll_sel_i = 1'b0; spread_en_i = 1'b1;
    repeat (int'(p) + 2 * (int'(tc) + 1)) @(negedge clk);
    observe(2 * p + 4, pk);
    check(o_below == 0, "R2 below nominal count", o_below, 0);
    check(o_max == pk, "R3 peak ratio", o_max, pk);
    check(o_min == nom, "R3 minimum ratio", o_min, nom);
    check(o_step <= f_step(nom, code), "R4 per-cycle step", o_step, f_step(nom, code));
    check(o_starts >= 2 && (o_t2 - o_t1) == p, "R5 modulation period", o_t2 - o_t1, p);
  endtask

  task automatic gated(input longint nom, input longint code, input bit cap, input bit pll,
                       input bit en, input string req);
    longint p = f_period(3);
    drain();
    nom_ratio_i = RATIO_W'(nom); depth_code_i = CODE_W'(code); rate_tc_i = TC_W'(3);
    spread_cap_i = cap; pll_sel_i = pll; spread_en_i = en;
    observe(2 * p + 8, -1);
    check(o_max == nom && o_min == nom, req, o_max, nom);
  endtask

  initial begin
    int unsigned seed_init = $urandom(32'd4711);
    longint nom, code, tc, p;
    seed_init = seed_init + 0;

    // R1: reset state
    nom_ratio_i = 32'd12_345_678; depth_code_i = 5'd20; spread_cap_i = 1'b1; spread_en_i = 1'b1;
    repeat (3) @(negedge clk);
    check(ratio_o == nom_ratio_i, "R1 ratio during reset", ratio_o, nom_ratio_i);
    rst_ni = 1'b1;
    @(negedge clk);
    check(ratio_o == nom_ratio_i, "R1 ratio after release", ratio_o, nom_ratio_i);

    // R3/R4/R5: random configurations
    for (int k = 0; k < 8; k++) begin
      nom  = longint'($urandom_range(32'h0fff_ffff, 32'h0040_0000));
      code = longint'($urandom_range(25, 1));
      tc   = longint'($urandom_range(7, 0));
      run_cfg(nom, code, tc);
    end

    // R3: depth boundaries
    run_cfg(64'd100_000_000, 1, 2);
    run_cfg(64'd100_000_000, 25, 2);

    // R5: modulation rate for 25 MHz and 27 MHz references
    run_cfg(64'd50_000_000, 15, 5);
    p = f_period(5);
    check(25_000_000 / p >= 30_000 && 25_000_000 / p <= 33_000, "R5 rate at 25 MHz", 25_000_000 / p, 31_500);
    run_cfg(64'd50_000_000, 15, 6);
    p = f_period(6);
    check(27_000_000 / p >= 30_000 && 27_000_000 / p <= 33_000, "R5 rate at 27 MHz", 27_000_000 / p, 31_500);

    // gating
    gated(64'd80_000_000, 10, 1'b1, 1'b0, 1'b0, "R6 global enable low");
    gated(64'd80_000_000, 10, 1'b1, 1'b1, 1'b1, "R7 second PLL source");
    gated(64'd80_000_000, 10, 1'b0, 1'b0, 1'b1, "R8 not spread-capable");
    gated(64'd80_000_000, 0,  1'b1, 1'b0, 1'b1, "R9 depth code 0");
    gated(64'd80_000_000, 26, 1'b1, 1'b0, 1'b1, "R9 depth code 26");
    gated(64'd80_000_000, 31, 1'b1, 1'b0, 1'b1, "R9 depth code 31");

    // R10: disable mid-ramp
    drain();
    nom = 64'd200_000_000; code = 20; tc = 3; p = f_period(tc);
    nom_ratio_i = RATIO_W'(nom); depth_code_i = CODE_W'(code); rate_tc_i = TC_W'(tc);
    spread_cap_i = 1'b1; pll_sel_i = 1'b0; spread_en_i = 1'b1;
    repeat (int'(p + p / 3)) @(negedge clk);
    spread_en_i = 1'b0;
    observe(p + 2 * (tc + 1) + 4, -1);
    check(o_first > nom, "R10 no snap to nominal on disable", o_first, nom + 1);
    check(o_step <= f_step(nom, code), "R10 ramp step after disable", o_step, f_step(nom, code));
    check(o_below == 0, "R10 below nominal count", o_below, 0);
    observe(p, -1);
    check(o_max == nom && o_min == nom, "R10 settled at nominal", o_max, nom);

    // R11: depth change takes effect at next minimum
    drain();
    nom = 64'd150_000_000; tc = 3; p = f_period(tc);
    nom_ratio_i = RATIO_W'(nom); depth_code_i = 5'd10; rate_tc_i = TC_W'(tc);
    spread_cap_i = 1'b1; pll_sel_i = 1'b0; spread_en_i = 1'b1;
    repeat (int'(tc + 1 + p / 4)) @(negedge clk);
    depth_code_i = 5'd25;
    observe(p / 2, -1);
    check(o_max == f_peak(nom, 10), "R11 current period keeps old depth", o_max, f_peak(nom, 10));
    observe(p, -1);
    check(o_max == f_peak(nom, 25), "R11 next period uses new depth", o_max, f_peak(nom, 25));

    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (190_000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 190_000, 0);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule